// File: doc/BRIEF.md
# Depth-Cascade Token Chain Controller

This block joins a ring of identical FIFO slices, each with its own storage and pointers, into one logical FIFO whose depth is the slice count times the slice depth. The controller does not hold any data. It keeps two ownership tokens. The write token marks the slice that takes the next global write, and the read token marks the slice that serves the next global read. Only the slice that holds the matching token receives the global write or read strobe. When that slice accepts the operation at its last physical location, it hands the token on to the next slice around the ring, and it raises a one-cycle expansion pulse that is tagged as a write event or a read event.

Each slice reports four things to the controller: its active-low full and empty flags, and whether its write pointer or its read pointer sits at the last physical location. The controller merges the per-slice flags into a composite full and a composite empty. It also selects the read data of the slice that holds the read token. One slice is chosen at build time as the first-load slice. After reset it holds both tokens and every other slice holds neither. Retransmit and a half-full output are not part of the cascaded arrangement.

Top module: `depth_cascade_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `wr_owner` and `rd_owner` become one-hot with only bit `FIRST_SLICE` set, and `wr_xo` and `rd_xo` become all zero.
- R2: `wr_sel[k]` equals `wr_req` AND `wr_owner[k]`, without delay. Exactly one bit of `wr_owner` is set at all times after reset.
- R3: `rd_sel[k]` equals `rd_req` AND `rd_owner[k]`, without delay. Exactly one bit of `rd_owner` is set at all times after reset.
- R4: Write handoff. Suppose that at a clock edge slice k holds the write token, `wr_req` is 1, `slice_full_n[k]` is 1 and `slice_wr_last[k]` is 1. Then after that edge `wr_owner` has only bit (k+1) mod SLICES set, so the last slice wraps to slice 0. In the same cycle `wr_xo` has only bit k set, for exactly one cycle.
- R5: Read handoff follows the same rule. The inputs are `rd_req`, `slice_empty_n[k]` and `slice_rd_last[k]`, and the outputs are `rd_owner` and `rd_xo`.
- R6: If the owner slice is not at its last location, if it is full (for a write) or empty (for a read), or if there is no request, the token stays where it is and the matching expansion output is zero. A write event never moves the read token, and a read event never moves the write token.
- R7: `full_n` is 0 only when every bit of `slice_full_n` is 0. `empty_n` is 0 only when every bit of `slice_empty_n` is 0.
- R8: `rd_data` equals the field `slice_rdata[k*DATA_W +: DATA_W]` of the slice k that holds the read token, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Global write strobe |
| rd_req | input | 1 | Global read strobe |
| slice_full_n | input | SLICES | Per-slice full flag, active low |
| slice_empty_n | input | SLICES | Per-slice empty flag, active low |
| slice_wr_last | input | SLICES | Slice write pointer is at its last physical location |
| slice_rd_last | input | SLICES | Slice read pointer is at its last physical location |
| slice_rdata | input | SLICES*DATA_W | Read data of every slice, slice k at bits k*DATA_W upward |
| wr_sel | output | SLICES | Write strobe steered to the slice holding the write token |
| rd_sel | output | SLICES | Read strobe steered to the slice holding the read token |
| wr_owner | output | SLICES | One-hot write token position |
| rd_owner | output | SLICES | One-hot read token position |
| wr_xo | output | SLICES | Write-tagged expansion pulse per slice |
| rd_xo | output | SLICES | Read-tagged expansion pulse per slice |
| rd_data | output | DATA_W | Read data from the read-token slice |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |

## Verification
The bench builds the block with SLICES = 4, DATA_W = 8 and FIRST_SLICE = 1. Because the first-load slice is not slice 0, a wrong reset position shows up, and a full walk of either token passes through the wrap from slice 3 back to slice 0. With four slices, the two tokens can also sit in different slices while handoffs are blocked by full or empty flags, so the independence of the write and read tokens and the steering of the read data are both exercised.

// File: rtl/cascade_pkg.sv
// Shared helpers for the depth-cascade controller.
// Assumes ring indices in the range 0 .. slices-1.
package cascade_pkg;

    // Index of the slice whose expansion output feeds slice idx (ring predecessor).
    function automatic int unsigned cascade_pred(input int unsigned idx, input int unsigned slices);
        return (idx + slices - 1) % slices;
    endfunction

endpackage

// File: rtl/cascade_slot.sv
// One token slot: holds one token bit for one slice.
// It steers the global strobe to its slice while it owns the token. It gives the
// token up when the slice accepts an operation at its last location, and it takes
// the token when the predecessor slot hands off (the expansion input).
// Assumes that at most one slot of a ring owns the token.
module cascade_slot #(
    parameter bit IS_FIRST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic avail,
    input  logic last,
    input  logic xi,
    output logic sel,
    output logic handoff,
    output logic own,
    output logic xo
);
    logic own_q;
    logic xo_q;

    // Steer the global strobe and detect an accepted last-location operation.
    assign sel     = req & own_q;
    assign handoff = sel & avail & last;

    // Token ownership and the registered expansion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= IS_FIRST;
            xo_q  <= 1'b0;
        end else begin
            xo_q <= handoff;
            if (handoff) begin
                own_q <= 1'b0;
            end else if (xi) begin
                own_q <= 1'b1;
            end
        end
    end

    assign own = own_q;
    assign xo  = xo_q;
endmodule

// File: rtl/cascade_token_ring.sv
// A ring of SLICES token slots for one kind of operation (write or read).
// The handoff of each slot drives the expansion input of the next slot, and
// the last slot wraps to slot 0.
// Assumes 2 <= SLICES <= 8 and FIRST_SLICE < SLICES.
module cascade_token_ring #(
    parameter int unsigned SLICES      = 4,
    parameter int unsigned FIRST_SLICE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SLICES-1:0] avail,
    input  logic [SLICES-1:0] last,
    output logic [SLICES-1:0] sel,
    output logic [SLICES-1:0] owner,
    output logic [SLICES-1:0] xo
);
    logic [SLICES-1:0] handoff;

    genvar k;
    generate
        for (k = 0; k < SLICES; k++) begin : g_slot
            localparam int unsigned PREV = cascade_pkg::cascade_pred(k, SLICES);
            localparam bit          FIRST_HERE = (k == FIRST_SLICE);
            cascade_slot #(.IS_FIRST(FIRST_HERE)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (req),
                .avail   (avail[k]),
                .last    (last[k]),
                .xi      (handoff[PREV]),
                .sel     (sel[k]),
                .handoff (handoff[k]),
                .own     (owner[k]),
                .xo      (xo[k])
            );
        end
    endgenerate
endmodule

// File: rtl/cascade_flag_merge.sv
// Merges the active-low per-slice flags into composite flags. A composite flag
// is asserted (low) only when the flag of every slice is asserted.
module cascade_flag_merge #(
    parameter int unsigned SLICES = 4
) (
    input  logic [SLICES-1:0] slice_full_n,
    input  logic [SLICES-1:0] slice_empty_n,
    output logic              full_n,
    output logic              empty_n
);
    // OR of the active-low flags = AND of the asserted conditions.
    assign full_n  = |slice_full_n;
    assign empty_n = |slice_empty_n;
endmodule

// File: rtl/cascade_rdata_mux.sv
// Selects the read data of the slice marked in a one-hot owner vector.
// Assumes the owner vector is one-hot.
module cascade_rdata_mux #(
    parameter int unsigned SLICES = 4,
    parameter int unsigned DATA_W = 9
) (
    input  logic [SLICES-1:0]        owner,
    input  logic [SLICES*DATA_W-1:0] slice_rdata,
    output logic [DATA_W-1:0]        rdata
);
    // AND-OR select, one term per slice.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < SLICES; k++) begin
            if (owner[k]) begin
                rdata = rdata | slice_rdata[k*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/depth_cascade_ctrl.sv
// Depth-cascade controller: joins SLICES FIFO slices into one logical FIFO.
// It steers the global write and read strobes to the slices that hold the
// tokens, passes each token around the ring on a last-location accept, merges
// the flags and selects the read data.
// Assumes 2 <= SLICES <= 8, FIFO slices outside the block, synchronous active-low reset.
module depth_cascade_ctrl #(
    parameter int unsigned SLICES      = 4,
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned FIRST_SLICE = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_req,
    input  logic                     rd_req,
    input  logic [SLICES-1:0]        slice_full_n,
    input  logic [SLICES-1:0]        slice_empty_n,
    input  logic [SLICES-1:0]        slice_wr_last,
    input  logic [SLICES-1:0]        slice_rd_last,
    input  logic [SLICES*DATA_W-1:0] slice_rdata,
    output logic [SLICES-1:0]        wr_sel,
    output logic [SLICES-1:0]        rd_sel,
    output logic [SLICES-1:0]        wr_owner,
    output logic [SLICES-1:0]        rd_owner,
    output logic [SLICES-1:0]        wr_xo,
    output logic [SLICES-1:0]        rd_xo,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     full_n,
    output logic                     empty_n
);
    // Write token ring: a slice can take a write when it is not full.
    cascade_token_ring #(.SLICES(SLICES), .FIRST_SLICE(FIRST_SLICE)) u_wr_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (wr_req),
        .avail (slice_full_n),
        .last  (slice_wr_last),
        .sel   (wr_sel),
        .owner (wr_owner),
        .xo    (wr_xo)
    );

    // Read token ring: a slice can serve a read when it is not empty.
    cascade_token_ring #(.SLICES(SLICES), .FIRST_SLICE(FIRST_SLICE)) u_rd_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (rd_req),
        .avail (slice_empty_n),
        .last  (slice_rd_last),
        .sel   (rd_sel),
        .owner (rd_owner),
        .xo    (rd_xo)
    );

    cascade_flag_merge #(.SLICES(SLICES)) u_flags (
        .slice_full_n  (slice_full_n),
        .slice_empty_n (slice_empty_n),
        .full_n        (full_n),
        .empty_n       (empty_n)
    );

    cascade_rdata_mux #(.SLICES(SLICES), .DATA_W(DATA_W)) u_rmux (
        .owner       (rd_owner),
        .slice_rdata (slice_rdata),
        .rdata       (rd_data)
    );
endmodule

// File: rtl/depth_cascade_checker.sv
// Property checker for depth_cascade_ctrl, attached with bind.
module depth_cascade_checker #(
    parameter int unsigned SLICES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SLICES-1:0] slice_full_n,
    input logic [SLICES-1:0] slice_empty_n,
    input logic [SLICES-1:0] slice_wr_last,
    input logic [SLICES-1:0] slice_rd_last,
    input logic [SLICES-1:0] wr_sel,
    input logic [SLICES-1:0] rd_sel,
    input logic [SLICES-1:0] wr_owner,
    input logic [SLICES-1:0] rd_owner,
    input logic [SLICES-1:0] wr_xo,
    input logic [SLICES-1:0] rd_xo,
    input logic              full_n,
    input logic              empty_n
);
    function automatic logic [SLICES-1:0] rot(input logic [SLICES-1:0] v);
        return {v[SLICES-2:0], v[SLICES-1]};
    endfunction

    logic wr_go, rd_go;
    assign wr_go = |(wr_sel & slice_full_n & slice_wr_last);
    assign rd_go = |(rd_sel & slice_empty_n & slice_rd_last);

    p_wr_sel_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel & ~wr_owner) == '0);
    p_wr_one_token_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_owner) == 1);
    p_rd_sel_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel & ~rd_owner) == '0);
    p_rd_one_token_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_owner) == 1);
    p_wr_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (wr_owner == rot($past(wr_owner))) && (wr_xo == $past(wr_owner)));
    p_rd_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> (rd_owner == rot($past(rd_owner))) && (rd_xo == $past(rd_owner)));
    p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_go |=> $stable(wr_owner) && (wr_xo == '0));
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_owner) && (rd_xo == '0));
    p_full_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> (slice_full_n == '0));
    p_empty_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n |-> (slice_empty_n == '0));
endmodule

bind depth_cascade_ctrl depth_cascade_checker #(.SLICES(SLICES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slice_full_n  (slice_full_n),
    .slice_empty_n (slice_empty_n),
    .slice_wr_last (slice_wr_last),
    .slice_rd_last (slice_rd_last),
    .wr_sel        (wr_sel),
    .rd_sel        (rd_sel),
    .wr_owner      (wr_owner),
    .rd_owner      (rd_owner),
    .wr_xo         (wr_xo),
    .rd_xo         (rd_xo),
    .full_n        (full_n),
    .empty_n       (empty_n)
);

// File: tb/sim_depth_cascade_ctrl.sv
module sim_depth_cascade_ctrl;
    localparam int SL = 4;
    localparam int DW = 8;
    localparam int FS = 1;

    logic clk = 1'b0;
    logic rst_n;
    logic wr_req, rd_req;
    logic [SL-1:0] slice_full_n, slice_empty_n, slice_wr_last, slice_rd_last;
    logic [SL*DW-1:0] slice_rdata;
    logic [SL-1:0] wr_sel, rd_sel, wr_owner, rd_owner, wr_xo, rd_xo;
    logic [DW-1:0] rd_data;
    logic full_n, empty_n;

    int checks = 0;
    int fails  = 0;
    int widx, ridx;

    always #5 clk = ~clk;

    depth_cascade_ctrl #(.SLICES(SL), .DATA_W(DW), .FIRST_SLICE(FS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .slice_full_n(slice_full_n), .slice_empty_n(slice_empty_n),
        .slice_wr_last(slice_wr_last), .slice_rd_last(slice_rd_last),
        .slice_rdata(slice_rdata), .wr_sel(wr_sel), .rd_sel(rd_sel),
        .wr_owner(wr_owner), .rd_owner(rd_owner), .wr_xo(wr_xo), .rd_xo(rd_xo),
        .rd_data(rd_data), .full_n(full_n), .empty_n(empty_n));

    function automatic logic [SL-1:0] hot(input int i);
        return SL'(1) << i;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then registered ones.
    task automatic cycle(input logic wq, input logic rq, input logic [SL-1:0] fn,
                         input logic [SL-1:0] en, input logic [SL-1:0] wl,
                         input logic [SL-1:0] rl, input logic [SL*DW-1:0] rdat);
        bit wh, rh;
        @(negedge clk);
        wr_req = wq; rd_req = rq; slice_full_n = fn; slice_empty_n = en;
        slice_wr_last = wl; slice_rd_last = rl; slice_rdata = rdat;
        #1;
        chk(wr_sel == (wq ? hot(widx) : '0), "R2 wr_sel", wr_sel, wq ? hot(widx) : '0);
        chk(rd_sel == (rq ? hot(ridx) : '0), "R3 rd_sel", rd_sel, rq ? hot(ridx) : '0);
        chk(rd_data == rdat[ridx*DW +: DW], "R8 rd_data", rd_data, rdat[ridx*DW +: DW]);
        chk(full_n == (fn != '0), "R7 full_n", full_n, fn != '0);
        chk(empty_n == (en != '0), "R7 empty_n", empty_n, en != '0);
        wh = wq && fn[widx] && wl[widx];
        rh = rq && en[ridx] && rl[ridx];
        @(posedge clk);
        #1;
        if (wh) begin
            chk(wr_xo == hot(widx), "R4 wr_xo", wr_xo, hot(widx));
            widx = (widx + 1) % SL;
            chk(wr_owner == hot(widx), "R4 wr_owner", wr_owner, hot(widx));
        end else begin
            chk(wr_xo == '0, "R6 wr_xo", wr_xo, 0);
            chk(wr_owner == hot(widx), "R6 wr_owner", wr_owner, hot(widx));
        end
        if (rh) begin
            chk(rd_xo == hot(ridx), "R5 rd_xo", rd_xo, hot(ridx));
            ridx = (ridx + 1) % SL;
            chk(rd_owner == hot(ridx), "R5 rd_owner", rd_owner, hot(ridx));
        end else begin
            chk(rd_xo == '0, "R6 rd_xo", rd_xo, 0);
            chk(rd_owner == hot(ridx), "R6 rd_owner", rd_owner, hot(ridx));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_req = 0; rd_req = 0;
        slice_full_n = '1; slice_empty_n = '1; slice_wr_last = '0; slice_rd_last = '0;
        slice_rdata = '0;
        repeat (2) @(posedge clk);
        #1;
        chk(wr_owner == hot(FS), "R1 wr_owner", wr_owner, hot(FS));
        chk(rd_owner == hot(FS), "R1 rd_owner", rd_owner, hot(FS));
        chk(wr_xo == '0 && rd_xo == '0, "R1 xo", {wr_xo, rd_xo}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        widx = FS; ridx = FS;
    endtask

    function automatic logic [SL-1:0] sparse();
        logic [SL-1:0] v;
        for (int i = 0; i < SL; i++) v[i] = ($urandom % 3) == 0;
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c4d));
        rst_n = 1'b0;
        do_reset();
        // R6: owner at last but full -> write token blocked; read at last but empty -> blocked.
        cycle(1, 1, ~hot(FS), ~hot(FS), '1, '1, 32'h44332211);
        // R6: at last location but no request.
        cycle(0, 0, '1, '1, '1, '1, 32'h88776655);
        // R4/R6: walk write token fully round the ring (wrap 3->0); read token idle.
        for (int i = 0; i < SL; i++) cycle(1, 0, '1, '1, '1, '1, 32'hA1B2C3D4);
        // R5: walk read token fully round; write token idle.
        for (int i = 0; i < SL; i++) cycle(0, 1, '1, '1, '1, '1, 32'h0F1E2D3C);
        // R4 and R5 together, tokens offset: move write once more, then both.
        cycle(1, 0, '1, '1, '1, '0, 32'h11111111);
        for (int i = 0; i < 6; i++) cycle(1, 1, '1, '1, '1, '1, $urandom);
        // R7: all flags asserted gives composite asserted.
        cycle(0, 0, '0, '0, '0, '0, $urandom);
        // Constrained random.
        for (int n = 0; n < 3000; n++) begin
            cycle($urandom % 4 != 0, $urandom % 4 != 0,
                  ($urandom % 8 == 0) ? '0 : SL'($urandom),
                  ($urandom % 8 == 0) ? '0 : SL'($urandom),
                  sparse(), sparse(), $urandom);
        end
        // R1: a second reset returns both tokens to the first-load slice.
        do_reset();
        cycle(1, 1, '1, '1, '0, '0, 32'hCAFEF00D);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule